// File: doc/BRIEF.md
# Video Stream Control-Packet Filter

This block sits between a video processing pipeline and a display output built in-house. Its input carries a packetised stream in which video packets and any number of control packets are mixed. The first beat of every packet, the one that carries start-of-packet, says what kind of packet it is. A zero there marks a video packet. Any other value marks a packet the block throws away whole.

For a video packet, the block consumes the leading zero beat. Only raw pixels leave the block. On the output, start-of-packet moves onto the first pixel and end-of-packet stays on the last pixel. The display side therefore sees plain frames. The block does not decode what control packets contain.

Both ports use ready/valid handshaking with a ready latency of one. A source may present a beat only in the cycle after its sink raised ready. A one-entry skid register absorbs a pixel that was accepted just as the downstream side stalled.

Top module: `vid_pkt_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid_o` is low and `in_ready_o` is high.
- R2: A packet whose start-of-packet beat holds a nonzero value produces no output beat, from any of its beats.
- R3: Any number of consecutive control packets ahead of a video packet are all discarded, and the following video packet passes intact.
- R4: The zero-valued start-of-packet beat of a video packet is never forwarded. The pixels that follow it leave unchanged and in arrival order.
- R5: `out_sop_o` is high on the first pixel of each video packet and only there. `out_eop_o` is high on the beat that carried input end-of-packet and only there.
- R6: `out_valid_o` is high only in a cycle that follows a cycle with `out_ready_i` high. This is ready latency one.
- R7: While no video packet is being passed, `in_ready_o` stays high whatever `out_ready_i` does, so discarded beats never stall.
- R8: Under any pattern of downstream stalls, every pixel reaches the output exactly once. Nothing is lost and nothing is duplicated.
- R9: A video packet consisting of one beat that carries both start-of-packet and end-of-packet produces no output. A beat with both flags always ends the packet.
- R10: Beats without start-of-packet that arrive outside a packet are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | DATA_W | Input beat data |
| in_valid_i | input | 1 | Input beat valid |
| in_sop_i | input | 1 | Input start of packet |
| in_eop_i | input | 1 | Input end of packet |
| in_ready_o | output | 1 | Ready to the source; its beat follows one cycle later |
| out_data_o | output | DATA_W | Output pixel data |
| out_valid_o | output | 1 | Output pixel valid |
| out_sop_o | output | 1 | High on the first pixel of a frame |
| out_eop_o | output | 1 | High on the last pixel of a frame |
| out_ready_i | input | 1 | Ready from the sink; it allows a beat one cycle later |

## Verification
Two things can land in the same cycle. The skid register can drain a held pixel while a fresh pixel is accepted and written into it. The type beat of the next packet can also be consumed while the previous packet's last pixel is still leaving the skid register. The bench provokes both cases with random downstream stalls against back-to-back input beats and short packets. A behavioural queue model judges every output beat by value, start flag and end flag, in order.

// File: rtl/vid_pkt_filter_pkg.sv
package vid_pkt_filter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_DROP = 2'd2
  } flt_state_e;
endpackage

// File: rtl/vid_pkt_fsm.sv
module vid_pkt_fsm
  import vid_pkt_filter_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sop_i,
  input  logic              eop_i,
  output flt_state_e        st_d_o,
  output logic              pix_o,
  output logic              pix_sop_o
);
  flt_state_e st_q, st_d;
  logic first_q, first_d;

  always_comb begin
    st_d    = st_q;
    first_d = first_q;
    pix_o   = 1'b0;
    if (acc_i) begin
      if (sop_i) begin
        // type beat: never forwarded
        if (eop_i)             st_d = ST_IDLE;
        else if (data_i == '0) begin st_d = ST_PASS; first_d = 1'b1; end
        else                   st_d = ST_DROP;
      end else begin
        unique case (st_q)
          ST_PASS: begin
            pix_o   = 1'b1;
            first_d = 1'b0;
            if (eop_i) st_d = ST_IDLE;
          end
          ST_DROP: if (eop_i) st_d = ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
    end
  end

  assign st_d_o    = st_d;
  assign pix_sop_o = first_q;
endmodule

// File: rtl/vid_pkt_skid.sv
module vid_pkt_skid #(
  parameter int BEAT_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              out_rdy_q_i,
  output logic              full_o,
  output logic              full_d_o,
  output logic              out_valid_o,
  output logic [BEAT_W-1:0] out_beat_o
);
  logic              full_q, full_d;
  logic [BEAT_W-1:0] beat_q, beat_d;

  always_comb begin
    full_d = full_q;
    beat_d = beat_q;
    if (full_q) begin
      if (out_rdy_q_i) begin
        if (pix_i) beat_d = beat_i;  // drain and refill in one cycle
        else       full_d = 1'b0;
      end
    end else if (pix_i && !out_rdy_q_i) begin
      full_d = 1'b1;
      beat_d = beat_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      beat_q <= '0;
    end else begin
      full_q <= full_d;
      beat_q <= beat_d;
    end
  end

  assign full_o      = full_q;
  assign full_d_o    = full_d;
  assign out_valid_o = out_rdy_q_i && (full_q || pix_i);
  assign out_beat_o  = full_q ? beat_q : beat_i;
endmodule

// File: rtl/vid_pkt_filter.sv
module vid_pkt_filter
  import vid_pkt_filter_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  output logic              in_ready_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  input  logic              out_ready_i
);
  localparam int BEAT_W = DATA_W + 2;

  logic in_rdy_q, out_rdy_q;
  logic acc, pix, pix_sop;
  logic skid_full, skid_full_d;
  flt_state_e st_d;
  logic [BEAT_W-1:0] pix_beat, out_beat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rdy_q  <= 1'b0;
      out_rdy_q <= 1'b0;
    end else begin
      in_rdy_q  <= in_ready_o;
      out_rdy_q <= out_ready_i;
    end
  end

  // a beat only counts if ready was given the cycle before
  assign acc = in_valid_i && in_rdy_q;

  vid_pkt_fsm #(.DATA_W(DATA_W)) fsm_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (acc),
    .data_i   (in_data_i),
    .sop_i    (in_sop_i),
    .eop_i    (in_eop_i),
    .st_d_o   (st_d),
    .pix_o    (pix),
    .pix_sop_o(pix_sop)
  );

  assign pix_beat = {pix_sop, in_eop_i, in_data_i};

  vid_pkt_skid #(.BEAT_W(BEAT_W)) skid_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pix_i      (pix),
    .beat_i     (pix_beat),
    .out_rdy_q_i(out_rdy_q),
    .full_o     (skid_full),
    .full_d_o   (skid_full_d),
    .out_valid_o(out_valid_o),
    .out_beat_o (out_beat)
  );

  // next beat can only stall if it is a pixel that finds a full skid and no output slot
  assign in_ready_o = (st_d != ST_PASS) || out_ready_i || !skid_full_d;

  assign out_sop_o  = out_beat[BEAT_W-1];
  assign out_eop_o  = out_beat[BEAT_W-2];
  assign out_data_o = out_beat[DATA_W-1:0];
endmodule

// File: rtl/vid_pkt_filter_chk.sv
module vid_pkt_filter_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc,
  input logic [DATA_W-1:0] in_data_i,
  input logic              in_sop_i,
  input logic              in_eop_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              skid_full,
  input logic              out_rdy_q,
  input logic              pix
);
  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(out_ready_i)); // R6

  AST_DROP_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_sop_i && !in_eop_i && in_data_i != '0) |-> in_ready_o); // R7

  AST_TYPE_NOT_FORWARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_sop_i && !skid_full) |-> !out_valid_o); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skid_full && !out_rdy_q) |-> !pix); // R8
endmodule

bind vid_pkt_filter vid_pkt_filter_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc        (acc),
  .in_data_i  (in_data_i),
  .in_sop_i   (in_sop_i),
  .in_eop_i   (in_eop_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .skid_full  (skid_full),
  .out_rdy_q  (out_rdy_q),
  .pix        (pix)
);

// File: tb/vid_pkt_filter_tb_top.sv
`timescale 1ns/1ps
module vid_pkt_filter_tb_top;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [DW-1:0] in_data = '0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [DW-1:0] out_data;

  vid_pkt_filter #(.DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_sop_i(in_sop), .in_eop_i(in_eop),
    .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_sop_o(out_sop), .out_eop_o(out_eop),
    .out_ready_i(out_ready)
  );

  typedef struct { logic [DW-1:0] d; bit s; bit e; } beat_t;
  beat_t inq[$];
  beat_t expq[$];

  int checks = 0, fails = 0, outs = 0, stall_pct = 0;
  bit gaps = 0, in_vid = 0, first = 0, rdy_prev = 0, oready_prev = 0;
  bit watch_rdy = 0, rdy_low = 0, done = 0;
  string cur_req = "R4";
  int unsigned pix_ctr = 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // behavioural model of the requirements
  function automatic void model(beat_t b);
    if (b.s) begin
      in_vid = (b.d == 0) && !b.e;
      first  = 1;
    end else if (in_vid) begin
      expq.push_back('{d: b.d, s: first, e: b.e});
      first = 0;
      if (b.e) in_vid = 0;
    end
  endfunction

  beat_t drv, ex;
  always @(negedge clk) if (rst_n && !done) begin
    oready_prev = out_ready;
    out_ready   = ($urandom_range(99) >= stall_pct);
    if (rdy_prev && inq.size() > 0 && !(gaps && $urandom_range(3) == 0)) begin
      drv = inq.pop_front();
      in_valid = 1; in_data = drv.d; in_sop = drv.s; in_eop = drv.e;
      model(drv);
    end else begin
      in_valid = 0; in_sop = 0; in_eop = 0; in_data = $urandom;
    end
    #1;
    rdy_prev = in_ready;
    if (watch_rdy && !in_ready) rdy_low = 1;
    if (out_valid) begin
      outs++;
      chk(oready_prev, "R6", "valid without prior ready", 0, 1);
      if (expq.size() == 0) chk(0, "R2", "unexpected output beat", out_data, 0);
      else begin
        ex = expq.pop_front();
        chk(out_data == ex.d, cur_req, "pixel data", out_data, ex.d);
        chk(out_sop == ex.s, "R5", "out_sop", out_sop, ex.s);
        chk(out_eop == ex.e, "R5", "out_eop", out_eop, ex.e);
      end
    end
  end

  task automatic push(logic [DW-1:0] d, bit s, bit e);
    inq.push_back('{d: d, s: s, e: e});
  endtask

  // n pixels; n==0 gives a single beat with both flags
  task automatic pkt(logic [DW-1:0] typ, int n);
    push(typ, 1, n == 0);
    for (int i = 0; i < n; i++) begin
      push(pix_ctr[DW-1:0], 0, i == n - 1);
      pix_ctr++;
    end
  endtask

  task automatic drain(string req);
    int n = 0;
    while ((inq.size() > 0 || expq.size() > 0) && n < 5000) begin
      @(posedge clk); n++;
    end
    repeat (4) @(posedge clk);
    chk(expq.size() == 0 && inq.size() == 0, req, "beats left pending", expq.size(), 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  initial begin
    int o0;
    repeat (3) @(posedge clk);
    #1;
    chk(!out_valid, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready, "R1", "in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready, "R1", "in_ready after reset", in_ready, 1);

    // R4 plain video packet
    cur_req = "R4"; pkt(0, 8); drain("R4");

    // R2 single control packet
    o0 = outs; pkt(24'h5, 6); drain("R2");
    chk(outs == o0, "R2", "outputs from control packet", outs - o0, 0);

    // R3 several control packets then video
    cur_req = "R3"; gaps = 1;
    pkt(24'h1, 3); pkt(24'hF, 1); pkt(24'hABCDEF, 5); pkt(0, 10); drain("R3");
    chk(outs == o0 + 10, "R3", "pixel count", outs - o0, 10);

    // R7 drop path ignores downstream stall
    stall_pct = 100; watch_rdy = 1; rdy_low = 0; o0 = outs;
    pkt(24'h7, 12); pkt(24'h2, 4); drain("R7");
    chk(!rdy_low, "R7", "in_ready low while dropping", rdy_low, 0);
    chk(outs == o0, "R7", "outputs during drop", outs - o0, 0);
    watch_rdy = 0; stall_pct = 0;

    // R9 empty video packet, then normal video
    o0 = outs; pkt(0, 0); drain("R9");
    chk(outs == o0, "R9", "outputs from empty video", outs - o0, 0);
    cur_req = "R9"; pkt(0, 3); drain("R9");

    // R10 stray beats outside any packet
    o0 = outs; push(24'h0, 0, 0); push(24'h11, 0, 1); push(24'h22, 0, 0); drain("R10");
    chk(outs == o0, "R10", "outputs from stray beats", outs - o0, 0);

    // R5 short back-to-back packets
    cur_req = "R5"; gaps = 0; stall_pct = 30;
    pkt(0, 1); pkt(0, 2); pkt(0, 1); pkt(24'h3, 0); pkt(0, 2); drain("R5");

    // R8 heavy stalls, long and mixed packets
    cur_req = "R8"; stall_pct = 50; gaps = 0;
    o0 = outs; pkt(0, 40); drain("R8");
    chk(outs == o0 + 40, "R8", "pixel count under stall", outs - o0, 40);
    gaps = 1; stall_pct = 40;
    for (int k = 0; k < 30; k++) begin
      if ($urandom_range(4) == 0) pkt($urandom_range(255, 1), $urandom_range(4));
      else pkt(0, $urandom_range(6));
    end
    drain("R8");

    summary();
  end
endmodule